// File: doc/BRIEF.md
# Fully Associative Victim Cache

This block is a small, fully associative store of whole cache lines that sits beside a direct-mapped first-level cache. A lookup is issued in the same cycle the first-level arrays are read, so the tag comparison against every entry runs alongside the first-level tag check. Both results are available in the following cycle. In that cycle the first-level cache reports whether it missed and, if so, which line it is displacing.

The store holds only lines pushed out of the first-level cache. If the first-level cache misses and this store also misses, the displaced line is written into a free entry, or into the least recently used entry when every entry is occupied. If the first-level cache misses and this store hits, the hit line goes out on the refill output and leaves the store. The displaced line takes over the freed slot and becomes the most recently used entry. Tags hold the full block address, which is the address without its byte offset, because no set index exists.

Control is a two-state machine. `ST_IDLE` accepts a request: the transition `T_ACCEPT` (request valid) moves to `ST_LOOK`, and with no request the machine stays (`T_WAIT`). `ST_LOOK` presents the result and applies the single update selected by the verdict of the first-level cache, then takes `T_DONE` back to `ST_IDLE`.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is invalid, `busy` and `resp_valid` are low, and any lookup misses.
- R2: A request accepted while `busy` is low produces `resp_valid` high for exactly one cycle, the cycle after acceptance. `resp_hit` is high only when a valid entry's tag equals address bits [ADDR_W-1:5]; the five byte-offset bits are ignored.
- R3: On a hit, `resp_line` carries the stored 256-bit line. On a miss, `resp_line` is all zeros.
- R4: In the response cycle, a miss here with `l1_miss` and `evict_valid` high stores the evicted line under the tag of `evict_addr`. A later lookup finds it, and a free slot is used before any valid entry is replaced.
- R5: When all entries are valid, such an insertion replaces the least recently used entry. That entry's line then misses, and every other entry still hits.
- R6: In the response cycle, a hit with `l1_miss` and `evict_valid` high removes the hit line, so a later lookup of it misses. The evicted line goes into the freed slot, so a later lookup of it hits.
- R7: A hit with `l1_miss` high and `evict_valid` low invalidates the hit entry. The next insertion then fills that slot without displacing any other entry.
- R8: An inserted or swapped-in line becomes the most recently used entry. It is the last of the current entries to be chosen for replacement.
- R9: When `l1_miss` is low in the response cycle, neither the stored lines nor the replacement order change.
- R10: A request raised while `busy` is high is ignored. No response follows it, and the contents are unchanged.
- R11: `busy` is high exactly in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, accepted when `busy` is low |
| req_addr | input | ADDR_W | Byte address of the lookup |
| busy | output | 1 | High in the response cycle; requests are ignored then |
| resp_valid | output | 1 | Lookup result is valid this cycle |
| resp_hit | output | 1 | Lookup found the block |
| resp_line | output | LINE_BYTES*8 | Line returned to the refill path (zero on miss) |
| l1_miss | input | 1 | First-level verdict for the current lookup, sampled in the response cycle |
| evict_valid | input | 1 | First-level cache is displacing a valid line, sampled in the response cycle |
| evict_addr | input | ADDR_W | Byte address of the displaced line |
| evict_line | input | LINE_BYTES*8 | Data of the displaced line |

## Verification
Each response is due one clock edge after the request edge. The bench raises the request at a falling edge, then reads `resp_valid`, `resp_hit` and `resp_line` at the next falling edge, halfway through the response cycle. The first-level verdict and the eviction inputs are applied at that same falling edge. Their effect on contents and replacement order shows only on the next lookup, two edges later. No check looks at internal state. A request raised during the response cycle is checked one falling edge later, when `resp_valid` must be low.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOOK = 1'b1
    } vc_state_e;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_INSERT = 2'd1,
        UPD_SWAP   = 2'd2,
        UPD_DROP   = 2'd3
    } vc_upd_e;

endpackage

// File: rtl/vc_store.sv
module vc_store #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 27,
    parameter int LINE_W  = 256,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic [LINE_W-1:0]                wr_line,
    input  logic                             clr_en,
    input  logic [IDX_W-1:0]                 clr_idx,
    output logic [ENTRIES-1:0][TAG_W-1:0]    tags,
    output logic [ENTRIES-1:0][LINE_W-1:0]   lines,
    output logic [ENTRIES-1:0]               valid
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel_wr;
        logic sel_clr;
        assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
        assign sel_clr = clr_en && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
            end else if (sel_wr) begin
                valid[g] <= 1'b1;
            end else if (sel_clr) begin
                valid[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[g]  <= '0;
                lines[g] <= '0;
            end else if (sel_wr) begin
                tags[g]  <= wr_tag;
                lines[g] <= wr_line;
            end
        end
    end

endmodule

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 27,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          any_hit,
    output logic [IDX_W-1:0]              hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim_idx,
    output logic [ENTRIES-1:0] oldest_vec
);

    logic [ENTRIES-1:0][IDX_W-1:0] age;
    logic [IDX_W-1:0]              touched_age;

    assign touched_age = age[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g)) begin
                    age[g] <= '0;
                end else if (age[g] < touched_age) begin
                    age[g] <= age[g] + 1'b1;
                end
            end
        end
        assign oldest_vec[g] = (age[g] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        logic found_free;
        found_free = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found_free && !valid[i]) begin
                victim_idx = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest_vec[i]) begin
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/victim_cache.sv
module victim_cache
    import vc_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int LINE_BYTES = 32,
    parameter int ADDR_W     = 32,
    localparam int OFFS_W    = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - OFFS_W,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_line,
    input  logic              l1_miss,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [LINE_W-1:0] evict_line
);

    vc_state_e state_q;
    vc_state_e state_d;
    vc_upd_e   upd;

    logic [TAG_W-1:0]              key_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0][LINE_W-1:0] lines;
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0]            hit_vec;
    logic [ENTRIES-1:0]            oldest_vec;
    logic                          any_hit;
    logic [IDX_W-1:0]              hit_idx;
    logic [IDX_W-1:0]              victim_idx;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              clr_en;
    logic              touch_en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request key capture: block address only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            key_q <= req_addr[ADDR_W-1:OFFS_W];
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;   // T_ACCEPT / T_WAIT
            ST_LOOK: state_d = ST_IDLE;                  // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and update selection
    always_comb begin
        busy       = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_line  = '0;
        upd        = UPD_NONE;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_LOOK: begin
                busy       = 1'b1;
                resp_valid = 1'b1;
                resp_hit   = any_hit;
                resp_line  = any_hit ? lines[hit_idx] : '0;
                if (l1_miss) begin
                    if (any_hit) begin
                        upd = evict_valid ? UPD_SWAP : UPD_DROP;
                    end else if (evict_valid) begin
                        upd = UPD_INSERT;
                    end
                end
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign wr_en    = (upd == UPD_SWAP) || (upd == UPD_INSERT);
    assign wr_idx   = (upd == UPD_SWAP) ? hit_idx : victim_idx;
    assign clr_en   = (upd == UPD_DROP);
    assign touch_en = wr_en;

    vc_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .LINE_W  (LINE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (evict_addr[ADDR_W-1:OFFS_W]),
        .wr_line (evict_line),
        .clr_en  (clr_en),
        .clr_idx (hit_idx),
        .tags    (tags),
        .lines   (lines),
        .valid   (valid_vec)
    );

    vc_match #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W)
    ) u_match (
        .tags    (tags),
        .valid   (valid_vec),
        .key     (key_q),
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    vc_lru #(
        .ENTRIES (ENTRIES)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (wr_idx),
        .valid      (valid_vec),
        .victim_idx (victim_idx),
        .oldest_vec (oldest_vec)
    );

endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               l1_miss,
    input logic               evict_valid,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] oldest_vec
);

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> resp_valid);

    p_single_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_busy_is_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy == resp_valid);

    p_unique_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_single_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec));

    p_insert_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit && l1_miss && evict_valid && ($countones(valid_vec) < ENTRIES))
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    p_drop_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit && l1_miss && !evict_valid)
        |=> ($countones(valid_vec) + 1 == $past($countones(valid_vec))));

    p_l1_hit_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !l1_miss) |=> $stable(valid_vec));

endmodule

bind victim_cache vc_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .l1_miss     (l1_miss),
    .evict_valid (evict_valid),
    .valid_vec   (valid_vec),
    .hit_vec     (hit_vec),
    .oldest_vec  (oldest_vec)
);

// File: tb/sim_victim_cache.sv
module sim_victim_cache;

    localparam int N      = 4;
    localparam int LB     = 32;
    localparam int AW     = 32;
    localparam int OW     = 5;
    localparam int TW     = AW - OW;
    localparam int LW     = LB * 8;
    localparam int POOL   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy;
    logic          resp_valid;
    logic          resp_hit;
    logic [LW-1:0] resp_line;
    logic          l1_miss = 1'b0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic [LW-1:0] evict_line = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [TW-1:0] m_tag  [N];
    logic [LW-1:0] m_line [N];
    bit            m_v    [N];
    int            m_age  [N];

    always #10 clk = ~clk;

    victim_cache #(.ENTRIES(N), .LINE_BYTES(LB), .ADDR_W(AW)) u0 (
        .clk, .rst_n, .req_valid, .req_addr, .busy, .resp_valid, .resp_hit,
        .resp_line, .l1_miss, .evict_valid, .evict_addr, .evict_line
    );

    function automatic logic [TW-1:0] pool_tag(int i);
        return TW'(27'h0ABCD00 ^ (i * 27'h111));
    endfunction

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] l;
        for (int k = 0; k < LW / 32; k++) l[k*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic int m_find(logic [TW-1:0] t);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
        return 0;
    endfunction

    function automatic void m_touch(int s);
        int a;
        a = m_age[s];
        for (int i = 0; i < N; i++) if (m_age[i] < a) m_age[i]++;
        m_age[s] = 0;
    endfunction

    task automatic chk(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one lookup; verdict applied in response cycle; model updated after
    task automatic access(logic [TW-1:0] t, logic [OW-1:0] offs, bit l1m, bit ev,
                          logic [TW-1:0] et, logic [LW-1:0] el, string req);
        int h;
        @(negedge clk);
        chk(busy == 1'b0, "R11 idle before request", LW'(busy), 0);
        req_valid = 1'b1;
        req_addr  = {t, offs};
        l1_miss = 1'b0; evict_valid = 1'b0;
        @(negedge clk);
        req_valid   = 1'b0;
        l1_miss     = l1m;
        evict_valid = ev;
        evict_addr  = {et, OW'($urandom)};
        evict_line  = el;
        h = m_find(t);
        chk(resp_valid == 1'b1 && busy == 1'b1, {req, " R2 R11 response due"}, LW'({resp_valid, busy}), 3);
        chk(resp_hit == (h >= 0), {req, " R2 hit flag"}, LW'(resp_hit), LW'(h >= 0));
        chk(resp_line == ((h >= 0) ? m_line[h] : '0), {req, " R3 line"}, resp_line,
            (h >= 0) ? m_line[h] : '0);
        if (l1m) begin
            if (h >= 0) begin
                if (ev) begin
                    m_tag[h] = et; m_line[h] = el; m_touch(h);
                end else begin
                    m_v[h] = 1'b0;
                end
            end else if (ev) begin
                int v;
                v = m_victim();
                m_tag[v] = et; m_line[v] = el; m_v[v] = 1'b1; m_touch(v);
            end
        end
        @(posedge clk);
        #1;
        l1_miss = 1'b0; evict_valid = 1'b0;
    endtask

    task automatic probe(logic [TW-1:0] t, bit exp_hit, string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {t, OW'(0)};
        @(negedge clk);
        req_valid = 1'b0; l1_miss = 1'b0;
        chk(resp_hit == exp_hit, req, LW'(resp_hit), LW'(exp_hit));
        @(posedge clk);
        #1;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_age[i] = i; m_tag[i] = '0; m_line[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(busy == 0 && resp_valid == 0, "R1 reset outputs", LW'({busy, resp_valid}), 0);
        access(pool_tag(0), 0, 1'b0, 1'b0, '0, '0, "R1 empty lookup");
        probe(pool_tag(1), 1'b0, "R1 empty probe");

        // R4 fill four free slots
        for (int i = 0; i < N; i++)
            access(pool_tag(7), 0, 1'b1, 1'b1, pool_tag(i), rand_line(), "R4 insert");
        for (int i = 0; i < N; i++)
            access(pool_tag(i), 0, 1'b0, 1'b0, '0, '0, "R4 R9 findable");

        // R5 full: fifth insert replaces oldest (pool 0)
        access(pool_tag(6), 0, 1'b1, 1'b1, pool_tag(4), rand_line(), "R5 replace");
        probe(pool_tag(0), 1'b0, "R5 LRU line gone");
        probe(pool_tag(1), 1'b1, "R5 others kept");

        // R2 offset ignored
        access(pool_tag(1), 5'h1F, 1'b0, 1'b0, '0, '0, "R2 offset ignored");

        // R6 swap: hit on pool 2, L1 displaces pool 0
        access(pool_tag(2), 0, 1'b1, 1'b1, pool_tag(0), rand_line(), "R6 swap");
        probe(pool_tag(2), 1'b0, "R6 returned line removed");
        probe(pool_tag(0), 1'b1, "R6 evicted line present");

        // R8 order now (oldest first): 1,3,4,0 -> next two inserts drop 1 then 3
        access(pool_tag(6), 0, 1'b1, 1'b1, pool_tag(5), rand_line(), "R8 insert a");
        probe(pool_tag(1), 1'b0, "R8 oldest out");
        probe(pool_tag(0), 1'b1, "R8 swapped line kept as recent");

        // R7 drop: hit with no eviction frees a slot
        access(pool_tag(3), 0, 1'b1, 1'b0, '0, '0, "R7 drop");
        probe(pool_tag(3), 1'b0, "R7 dropped gone");
        access(pool_tag(6), 0, 1'b1, 1'b1, pool_tag(2), rand_line(), "R7 refill free slot");
        probe(pool_tag(4), 1'b1, "R7 no displacement 4");
        probe(pool_tag(0), 1'b1, "R7 no displacement 0");
        probe(pool_tag(5), 1'b1, "R7 no displacement 5");

        // R9 L1 hit verdict changes nothing even with evict inputs high
        access(pool_tag(4), 0, 1'b0, 1'b1, pool_tag(7), rand_line(), "R9 l1 hit");
        probe(pool_tag(7), 1'b0, "R9 nothing inserted");
        probe(pool_tag(4), 1'b1, "R9 entry retained");

        // R10 request during busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_addr = {pool_tag(0), OW'(0)};
        @(negedge clk);
        req_addr = {pool_tag(4), OW'(0)};  // held high while busy
        l1_miss = 1'b1; evict_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; l1_miss = 1'b0;
        chk(resp_valid == 1'b0, "R10 no response to busy request", LW'(resp_valid), 0);
        m_v[m_find(pool_tag(0))] = 1'b0;    // first request dropped pool 0 (R7)
        access(pool_tag(4), 0, 1'b0, 1'b0, '0, '0, "R10 contents unchanged");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int ri, ej, st;
            bit l1m, ev;
            ri  = $urandom % POOL;
            l1m = ($urandom % 4) != 0;
            ev  = 1'b0; ej = 0;
            st  = $urandom % POOL;
            for (int k = 0; k < POOL; k++) begin
                int j;
                j = (st + k) % POOL;
                if (!ev && j != ri && m_find(pool_tag(j)) < 0) begin ev = 1'b1; ej = j; end
            end
            if (($urandom % 5) == 0) ev = 1'b0;
            access(pool_tag(ri), OW'($urandom), l1m, ev, pool_tag(ej), rand_line(), "R2 R3 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule